// File: doc/BRIEF.md
# Ternary-Coded NAND Half-Buffer Cell

This block is a clocked behavioural model of one stage of a fine-grain, delay-insensitive pipeline. The stage merges the logic function and the pipeline register. Every data wire carries one of three levels: low, middle or high. Low and high are the two data values and middle is the empty (NULL) spacer. Here each level is a 2-bit code. The cell computes a two-input NAND. It holds the result until the next stage asks for the spacer, then returns to NULL and tells the previous stage when it is ready for new data.

Two one-bit request lines carry the handshake. One comes from the successor and one goes to the predecessor. On both lines a 1 means "ready for data" and a 0 means "ready for the spacer". Each input passes through a level decoder that yields an is-data flag, an is-low flag and an is-high flag. The NAND is formed only from those flags. The cell cycles through four phases: evaluate, hold data, precharge to NULL, and hold NULL. Cells are chained by feeding one cell's output into the next cell's inputs and that cell's predecessor request back into the first cell's successor request.

Top module: `tern_nand_cell`

## Requirements
- R1: Level codes on xIn, yIn and fOut are 2'b00 = data low (logic 0), 2'b01 = NULL and 2'b10 = data high (logic 1). fOut never carries 2'b11.
- R2: fOut never moves directly from one data value to a different data value. Between any two data results it passes through NULL.
- R3: When reqToPred is 1, reqFromSucc is 1, fOut is NULL and both inputs are data, fOut takes NAND(x,y) one clock later: 2'b00 if both inputs are 2'b10, otherwise 2'b10. reqToPred is still 1 in that cycle.
- R4: reqToPred falls to 0 one clock after fOut holds data while both inputs are data. It falls at no other time.
- R5: While reqToPred is 0 and reqFromSucc is 1, a data value on fOut is held unchanged.
- R6: When reqToPred and reqFromSucc are both 0, fOut is NULL one clock later.
- R7: reqToPred rises to 1 one clock after fOut is NULL and both inputs are NULL. It stays 0 while any of these is not true.
- R8: fOut stays NULL in three cases: reqFromSucc returns to 1 before the inputs go NULL; the inputs go NULL before reqFromSucc returns; both requests are 1 while an input is NULL.
- R9: The code 2'b11 on an input is decoded as NULL: it neither evaluates nor completes a handshake. It sets errFlag, which stays 1 until reset.
- R10: During and after reset, fOut is NULL (2'b01), reqToPred is 1 and errFlag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| xIn | input | 2 | First ternary operand |
| yIn | input | 2 | Second ternary operand |
| reqFromSucc | input | 1 | Request from successor: 1 = ready for data, 0 = ready for NULL |
| fOut | output | 2 | Ternary NAND result |
| reqToPred | output | 1 | Request to predecessor: 1 = ready for data, 0 = ready for NULL |
| errFlag | output | 1 | Sticky flag: an input carried the unused code |

## Verification
The bench walks every operand pair through a full handshake cycle. It alternates which of two events comes first: the successor's request returning to data, or the inputs returning to NULL. A cell that ignored its own predecessor request in that window would evaluate the stale operands again and emit a second data token. A single data operand with a NULL partner must not fire the gate; a cell that decoded only one input would release a token early. The unused code must look like NULL. An RTL that treated it as high would produce a result and drop the request to the predecessor. A three-cell chain with random sink delays checks that tokens arrive in order and that every output returns to NULL between tokens. A cell that let data overwrite data would produce a direct low-to-high step there.

// File: rtl/tern_cell_pkg.sv
package tern_cell_pkg;
  localparam int LEVEL_W = 2;
  localparam logic [LEVEL_W-1:0] LVL_LOW  = 2'b00;
  localparam logic [LEVEL_W-1:0] LVL_NULL = 2'b01;
  localparam logic [LEVEL_W-1:0] LVL_HIGH = 2'b10;
  localparam logic [LEVEL_W-1:0] LVL_BAD  = 2'b11;
  localparam int NUM_OPS = 2;

  typedef struct packed {
    logic isData;
    logic isLow;
    logic isHigh;
    logic isBad;
  } levelFlags_t;

  typedef struct packed {
    logic evalEn;
    logic precharge;
  } cellStrobe_t;

  typedef struct packed {
    logic xData;
    logic yData;
    logic fNull;
  } cellStatus_t;
endpackage

// File: rtl/tern_level_decode.sv
module tern_level_decode
  import tern_cell_pkg::*;
(
  input  logic [LEVEL_W-1:0] levelIn,
  output levelFlags_t        flags
);
  always_comb begin
    flags.isLow  = (levelIn == LVL_LOW);
    flags.isHigh = (levelIn == LVL_HIGH);
    flags.isBad  = (levelIn == LVL_BAD);
    flags.isData = flags.isLow | flags.isHigh;
  end
endmodule

// File: rtl/tern_nand_datapath.sv
module tern_nand_datapath
  import tern_cell_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [LEVEL_W-1:0] xIn,
  input  logic [LEVEL_W-1:0] yIn,
  input  cellStrobe_t        strobe,
  output cellStatus_t        status,
  output logic [LEVEL_W-1:0] fOut,
  output logic               errFlag
);
  logic [LEVEL_W-1:0] opLevel [NUM_OPS];
  levelFlags_t        opFlags [NUM_OPS];
  logic [LEVEL_W-1:0] fReg;
  logic [LEVEL_W-1:0] nandLevel;
  logic               errReg;
  logic               nandOne;
  logic               nandZero;
  logic               anyBad;

  assign opLevel[0] = xIn;
  assign opLevel[1] = yIn;

  for (genvar g = 0; g < NUM_OPS; g++) begin : gen_dec
    tern_level_decode u_dec (
      .levelIn(opLevel[g]),
      .flags  (opFlags[g])
    );
  end

  always_comb begin
    nandOne  = opFlags[0].isLow | opFlags[1].isLow;
    nandZero = opFlags[0].isHigh & opFlags[1].isHigh;
    if (nandOne)       nandLevel = LVL_HIGH;
    else if (nandZero) nandLevel = LVL_LOW;
    else               nandLevel = LVL_NULL;
    anyBad = opFlags[0].isBad | opFlags[1].isBad;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fReg   <= LVL_NULL;
      errReg <= 1'b0;
    end else begin
      if (strobe.precharge)   fReg <= LVL_NULL;
      else if (strobe.evalEn) fReg <= nandLevel;
      if (anyBad) errReg <= 1'b1;
    end
  end

  assign status.xData = opFlags[0].isData;
  assign status.yData = opFlags[1].isData;
  assign status.fNull = (fReg == LVL_NULL);
  assign fOut    = fReg;
  assign errFlag = errReg;
endmodule

// File: rtl/tern_nand_ctrl.sv
module tern_nand_ctrl
  import tern_cell_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reqFromSucc,
  input  cellStatus_t status,
  output cellStrobe_t strobe,
  output logic        reqToPred
);
  logic wantData;
  logic bothData;
  logic bothNull;

  assign bothData = status.xData & status.yData;
  assign bothNull = ~status.xData & ~status.yData;

  always_comb begin
    strobe.evalEn    = wantData & reqFromSucc & bothData & status.fNull;
    strobe.precharge = ~wantData & ~reqFromSucc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wantData <= 1'b1;
    end else if (wantData && !status.fNull && bothData) begin
      wantData <= 1'b0;
    end else if (!wantData && status.fNull && bothNull) begin
      wantData <= 1'b1;
    end
  end

  assign reqToPred = wantData;
endmodule

// File: rtl/tern_nand_cell.sv
module tern_nand_cell
  import tern_cell_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  xIn,
  input  logic [1:0]  yIn,
  input  logic        reqFromSucc,
  output logic [1:0]  fOut,
  output logic        reqToPred,
  output logic        errFlag
);
  cellStrobe_t strobe;
  cellStatus_t status;

  tern_nand_datapath u_dp (
    .clk    (clk),
    .rst    (rst),
    .xIn    (xIn),
    .yIn    (yIn),
    .strobe (strobe),
    .status (status),
    .fOut   (fOut),
    .errFlag(errFlag)
  );

  tern_nand_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .reqFromSucc(reqFromSucc),
    .status     (status),
    .strobe     (strobe),
    .reqToPred  (reqToPred)
  );
endmodule

// File: rtl/tern_nand_cell_chk.sv
module tern_nand_cell_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] xIn,
  input logic [1:0] yIn,
  input logic       reqFromSucc,
  input logic [1:0] fOut,
  input logic       reqToPred,
  input logic       errFlag
);
  logic xIsData;
  logic yIsData;
  assign xIsData = (xIn == 2'b00) || (xIn == 2'b10);
  assign yIsData = (yIn == 2'b00) || (yIn == 2'b10);

  // R1
  no_bad_output_chk: assert property (@(posedge clk) disable iff (rst)
    fOut != 2'b11);

  // R2
  no_data_jump_chk: assert property (@(posedge clk) disable iff (rst)
    (fOut != 2'b01 && $past(fOut) != 2'b01) |-> fOut == $past(fOut));

  // R3
  eval_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (fOut != 2'b01 && $past(fOut) == 2'b01) |->
      $past(reqToPred && reqFromSucc && xIsData && yIsData));

  // R4
  pred_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(reqToPred) |-> $past(fOut != 2'b01 && xIsData && yIsData));

  // R6
  precharge_chk: assert property (@(posedge clk) disable iff (rst)
    (!reqToPred && !reqFromSucc) |=> fOut == 2'b01);

  // R7
  pred_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(reqToPred) |-> $past(fOut == 2'b01 && !xIsData && !yIsData));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    errFlag |=> errFlag);
endmodule

bind tern_nand_cell tern_nand_cell_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .xIn        (xIn),
  .yIn        (yIn),
  .reqFromSucc(reqFromSucc),
  .fOut       (fOut),
  .reqToPred  (reqToPred),
  .errFlag    (errFlag)
);

// File: tb/tern_nand_cell_bench.sv
`timescale 1ns/1ps
module tern_nand_cell_bench;
  localparam logic [1:0] LO = 2'b00;
  localparam logic [1:0] NU = 2'b01;
  localparam logic [1:0] HI = 2'b10;
  localparam logic [1:0] BD = 2'b11;
  localparam int NVEC = 4;
  localparam int NTOK = 8;

  // {x, y, expected f, inputs-null-first}
  localparam logic [6:0] VEC [NVEC] = '{
    {LO, LO, HI, 1'b1},
    {LO, HI, HI, 1'b0},
    {HI, LO, HI, 1'b1},
    {HI, HI, LO, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  logic [1:0] xIn = NU, yIn = NU;
  logic       req = 1'b1;
  logic [1:0] fOut;
  logic       reqToPred, errFlag;

  tern_nand_cell u_tern_nand_cell (
    .clk(clk), .rst(rst), .xIn(xIn), .yIn(yIn), .reqFromSucc(req),
    .fOut(fOut), .reqToPred(reqToPred), .errFlag(errFlag)
  );

  // three-cell chain: A -> B (inverter) -> C (inverter)
  logic [1:0] srcX = NU, srcY = NU;
  logic       sinkReq = 1'b1;
  logic [1:0] aF, bF, cF;
  logic       aReq, bReq, cReq, aErr, bErr, cErr;

  tern_nand_cell u_chainA (.clk(clk), .rst(rst), .xIn(srcX), .yIn(srcY),
    .reqFromSucc(bReq), .fOut(aF), .reqToPred(aReq), .errFlag(aErr));
  tern_nand_cell u_chainB (.clk(clk), .rst(rst), .xIn(aF), .yIn(aF),
    .reqFromSucc(cReq), .fOut(bF), .reqToPred(bReq), .errFlag(bErr));
  tern_nand_cell u_chainC (.clk(clk), .rst(rst), .xIn(bF), .yIn(bF),
    .reqFromSucc(sinkReq), .fOut(cF), .reqToPred(cReq), .errFlag(cErr));

  task automatic chk(input string req_s, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req_s, act, exp, $time);
    end
  endtask

  // R2: every watched output passes through NULL between data values
  logic [1:0] prevF [4];
  initial for (int k = 0; k < 4; k++) prevF[k] = NU;
  always @(negedge clk) begin
    logic [1:0] cur [4];
    cur[0] = fOut; cur[1] = aF; cur[2] = bF; cur[3] = cF;
    if (!rst) begin
      for (int k = 0; k < 4; k++) begin
        if (cur[k] != NU && cur[k] != prevF[k]) begin
          checks++;
          if (prevF[k] != NU) begin
            fails++;
            $display("FAIL R2: output %0d actual %b expected %b (via NULL)", k, cur[k], NU);
          end
        end
      end
    end
    for (int k = 0; k < 4; k++) prevF[k] = cur[k];
  end

  task automatic run_vec(input logic [1:0] x, input logic [1:0] y,
                         input logic [1:0] e, input logic nullFirst);
    @(negedge clk); xIn = x; yIn = y; req = 1'b1;
    @(negedge clk); chk("R3 result", fOut, e); chk("R3 req still high", {1'b0, reqToPred}, 2'b01);
    @(negedge clk); chk("R4 req falls", {1'b0, reqToPred}, 2'b00);
    repeat (3) @(negedge clk);
    chk("R5 hold data", fOut, e);
    req = 1'b0;
    @(negedge clk); chk("R6 precharge", fOut, NU); chk("R7 no rise while data in", {1'b0, reqToPred}, 2'b00);
    if (nullFirst) begin
      xIn = NU; yIn = NU;
      @(negedge clk); chk("R7 rise", {1'b0, reqToPred}, 2'b01); chk("R8 null first", fOut, NU);
      req = 1'b1;
      @(negedge clk); chk("R8 both ready no data", fOut, NU);
    end else begin
      req = 1'b1;
      repeat (2) @(negedge clk);
      chk("R8 succ returns first", fOut, NU); chk("R7 held low", {1'b0, reqToPred}, 2'b00);
      xIn = NU; yIn = NU;
      @(negedge clk); chk("R7 rise", {1'b0, reqToPred}, 2'b01);
    end
    xIn = HI; yIn = NU;
    repeat (2) @(negedge clk);
    chk("R8 partial input", fOut, NU); chk("R8 req stays", {1'b0, reqToPred}, 2'b01);
    xIn = NU;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 f reset", fOut, NU);
    chk("R10 req reset", {1'b0, reqToPred}, 2'b01);
    chk("R10 err reset", {1'b0, errFlag}, 2'b00);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++)
      run_vec(VEC[i][6:5], VEC[i][4:3], VEC[i][2:1], VEC[i][0]);

    // R9: unused code acts as NULL and sets sticky flag
    @(negedge clk); xIn = BD; yIn = HI; req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 bad no eval", fOut, NU);
    chk("R9 bad no handshake", {1'b0, reqToPred}, 2'b01);
    chk("R9 flag set", {1'b0, errFlag}, 2'b01);
    xIn = NU;
    repeat (2) @(negedge clk);
    chk("R9 flag sticky", {1'b0, errFlag}, 2'b01);
    run_vec(HI, HI, LO, 1'b1);
    chk("R9 flag still set", {1'b0, errFlag}, 2'b01);
    rst = 1'b1;
    @(negedge clk);
    chk("R10 err cleared", {1'b0, errFlag}, 2'b00);
    rst = 1'b0;

    // chain with random sink timing
    fork
      begin
        for (int i = 0; i < NTOK; i++) begin
          while (!aReq) @(negedge clk);
          srcX = i[0] ? HI : LO; srcY = i[1] ? HI : LO;
          while (aReq) @(negedge clk);
          srcX = NU; srcY = NU;
          repeat ($urandom_range(0, 2)) @(negedge clk);
        end
      end
      begin
        for (int i = 0; i < NTOK; i++) begin
          while (cF == NU) @(negedge clk);
          chk("R3 chain token", cF, (i[0] && i[1]) ? LO : HI);
          repeat ($urandom_range(0, 4)) @(negedge clk);
          sinkReq = 1'b0;
          while (cF != NU) @(negedge clk);
          repeat ($urandom_range(0, 4)) @(negedge clk);
          sinkReq = 1'b1;
        end
      end
    join
    repeat (5) @(negedge clk);
    chk("R9 chain no error", {1'b0, aErr | bErr | cErr}, 2'b00);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule